// File: doc/BRIEF.md
# Dual-Port Test Pattern Generator

This block sits between a dual-channel data converter and its digital output pins. In normal operation it registers the converter words for channels I and Q on both output ports, A and B, and passes them on. When a 10-bit test configuration word enables testing, it replaces those words with known data, so the whole digital output path can be checked quickly without an analog signal.

Two test types exist. The static type drives an 8-bit pattern taken from the configuration word onto both B ports and drives its bitwise inverse onto both A ports. The dynamic type drives an 8-bit ramp: it counts up on the B ports and counts down on the A ports, because A always carries the complement of B. All outputs are registered on the sample clock. A configuration change therefore reaches the pins cleanly at the next clock edge. Dynamic testing is meant for sample clocks up to 750 Msps.

Top module: `bitgen_top`

## Requirements
- R1: While `rst_n` is low, all four output ports read 0.
- R2: When configuration bit 0 is 0, each output port shows the matching normal input word sampled at the previous rising edge.
- R3: When configuration bits [1:0] are 2'b01 (static test), both B ports show configuration bits [9:2] from the previous rising edge.
- R4: In static test, both A ports show the bitwise inverse of configuration bits [9:2] from the previous rising edge.
- R5: When configuration bits [1:0] are 2'b11 (dynamic test), both B ports show a ramp that rises by one on every clock and wraps from 255 to 0.
- R6: Whenever testing is active, each A port equals the bitwise complement of the B port of the same channel, so in dynamic test A falls from 255 to 0 as B rises.
- R7: On the first clock of dynamic test after reset, after inactive mode or after static test, the B ports show 0.
- R8: Every configuration change takes effect at the next rising edge, and the outputs change only at rising edges.
- R9: When bit 0 is 0, bit 1 and the pattern bits have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| testCfg | input | 10 | Test configuration: [0] enable, [1] dynamic select, [9:2] static pattern |
| normAI | input | 8 | Converter word for port A, channel I |
| normAQ | input | 8 | Converter word for port A, channel Q |
| normBI | input | 8 | Converter word for port B, channel I |
| normBQ | input | 8 | Converter word for port B, channel Q |
| outAI | output | 8 | Output port A, channel I |
| outAQ | output | 8 | Output port A, channel Q |
| outBI | output | 8 | Output port B, channel I |
| outBQ | output | 8 | Output port B, channel Q |

## Verification
The assertions assume that `testCfg` and the normal data words are stable at each rising edge and hold a known value from the first edge after reset onward. They also assume that `rst_n` is released at a clock edge. The bench meets these assumptions by changing every input at the falling edge only and by driving all inputs to defined values before releasing reset. The ramp assertions also assume that the configuration may change on any cycle, so the stimulus moves between inactive, static and dynamic modes back to back to exercise the restart rule.

// File: rtl/bitgen_pkg.sv
package bitgen_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic selTest;   // test data replaces converter data
    logic selDyn;    // ramp instead of static pattern
    logic rampClear; // first dynamic cycle: ramp restarts at zero
  } bitStrb_t;
endpackage

// File: rtl/bitgen_ctrl.sv
module bitgen_ctrl
  import bitgen_pkg::*;
#(
  parameter int CFG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] testCfg,
  output bitStrb_t         strb
);
  logic dynPrev;
  logic dynNow;

  assign dynNow = testCfg[0] & testCfg[1];

  always_ff @(posedge clk) begin
    if (!rst_n) dynPrev <= 1'b0;
    else        dynPrev <= dynNow;
  end

  always_comb begin
    strb.selTest   = testCfg[0];
    strb.selDyn    = dynNow;
    strb.rampClear = ~dynPrev;
  end

  // R7: a clear strobe is raised on the first dynamic cycle only
  assert_clear_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.selDyn && $past(strb.selDyn) && rst_n && $past(rst_n)) |-> !strb.rampClear);
endmodule

// File: rtl/bitgen_dpath.sv
module bitgen_dpath
  import bitgen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bitStrb_t          strb,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] normA [NUM_CH],
  input  logic [DATA_W-1:0] normB [NUM_CH],
  output logic [DATA_W-1:0] outA  [NUM_CH],
  output logic [DATA_W-1:0] outB  [NUM_CH]
);
  logic [DATA_W-1:0] rampCnt;
  logic [DATA_W-1:0] rampNext;

  assign rampNext = strb.rampClear ? '0 : rampCnt + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)           rampCnt <= '0;
    else if (strb.selDyn) rampCnt <= rampNext;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] testB;
    assign testB = strb.selDyn ? rampNext : pattern;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        outA[ch] <= '0;
        outB[ch] <= '0;
      end else if (strb.selTest) begin
        outA[ch] <= ~testB;
        outB[ch] <= testB;
      end else begin
        outA[ch] <= normA[ch];
        outB[ch] <= normB[ch];
      end
    end

    // R6: A mirrors B while testing
    assert_a_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
      strb.selTest |=> (outA[ch] == ~outB[ch]));
  end

  // R5: ramp advances by one per clock while dynamic test continues
  assert_ramp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.selDyn && !strb.rampClear) |=> (outB[0] == $past(outB[0]) + DATA_W'(1)));

  // R7: ramp restarts at zero on entry to dynamic test
  assert_ramp_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.selDyn && strb.rampClear) |=> (outB[0] == '0));
endmodule

// File: rtl/bitgen_top.sv
module bitgen_top
  import bitgen_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CFG_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  testCfg,
  input  logic [DATA_W-1:0] normAI,
  input  logic [DATA_W-1:0] normAQ,
  input  logic [DATA_W-1:0] normBI,
  input  logic [DATA_W-1:0] normBQ,
  output logic [DATA_W-1:0] outAI,
  output logic [DATA_W-1:0] outAQ,
  output logic [DATA_W-1:0] outBI,
  output logic [DATA_W-1:0] outBQ
);
  localparam int NUM_CH = 2;

  bitStrb_t          strb;
  logic [DATA_W-1:0] normA [NUM_CH];
  logic [DATA_W-1:0] normB [NUM_CH];
  logic [DATA_W-1:0] outA  [NUM_CH];
  logic [DATA_W-1:0] outB  [NUM_CH];

  assign normA[0] = normAI;
  assign normA[1] = normAQ;
  assign normB[0] = normBI;
  assign normB[1] = normBQ;
  assign outAI = outA[0];
  assign outAQ = outA[1];
  assign outBI = outB[0];
  assign outBQ = outB[1];

  bitgen_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .testCfg (testCfg),
    .strb    (strb)
  );

  bitgen_dpath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .pattern (testCfg[CFG_W-1:2]),
    .normA   (normA),
    .normB   (normB),
    .outA    (outA),
    .outB    (outB)
  );

  // R2 / R9: inactive means pass-through, whatever the other bits hold
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !testCfg[0] |=> (outAI == $past(normAI) && outAQ == $past(normAQ) &&
                     outBI == $past(normBI) && outBQ == $past(normBQ)));

  // R3: static pattern on the B ports
  assert_static_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (testCfg[1:0] == 2'b01) |=> (outBI == $past(testCfg[CFG_W-1:2]) &&
                                 outBQ == $past(testCfg[CFG_W-1:2])));

  // R4: inverted static pattern on the A ports
  assert_static_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (testCfg[1:0] == 2'b01) |=> (outAI == ~$past(testCfg[CFG_W-1:2]) &&
                                 outAQ == ~$past(testCfg[CFG_W-1:2])));

  // R1: outputs held at zero in reset
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (outAI == '0 && outAQ == '0 && outBI == '0 && outBQ == '0));
endmodule

// File: tb/sim_bitgen_top.sv
`timescale 1ns/1ps
module sim_bitgen_top;
  typedef struct {
    logic [7:0] eAI, eAQ, eBI, eBQ;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] testCfg = '0;
  logic [7:0] normAI = '0, normAQ = '0, normBI = '0, normBQ = '0;
  logic [7:0] outAI, outAQ, outBI, outBQ;

  int nChecks = 0;
  int nFails  = 0;
  expItem_t expQ[$];
  logic dynPrevM = 1'b0;
  logic [7:0] rampM = '0;

  always #4 clk = ~clk;

  bitgen_top u0 (
    .clk(clk), .rst_n(rst_n), .testCfg(testCfg),
    .normAI(normAI), .normAQ(normAQ), .normBI(normBI), .normBQ(normBQ),
    .outAI(outAI), .outAQ(outAQ), .outBI(outBI), .outBQ(outBQ)
  );

  // driver: apply inputs at the falling edge and push the result due after the next rising edge
  task automatic step(input logic [9:0] cfg, input logic [7:0] ai, aq, bi, bq,
                      input string tag);
    expItem_t it;
    logic [7:0] b;
    @(negedge clk);
    testCfg = cfg; normAI = ai; normAQ = aq; normBI = bi; normBQ = bq;
    if (!cfg[0]) begin
      it.eAI = ai; it.eAQ = aq; it.eBI = bi; it.eBQ = bq;
      dynPrevM = 1'b0;
    end else begin
      if (cfg[1]) begin
        rampM = dynPrevM ? rampM + 8'd1 : 8'd0;
        b = rampM;
        dynPrevM = 1'b1;
      end else begin
        b = cfg[9:2];
        dynPrevM = 1'b0;
      end
      it.eBI = b; it.eBQ = b; it.eAI = ~b; it.eAQ = ~b;
    end
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      nChecks++;
      if (outAI !== it.eAI || outAQ !== it.eAQ || outBI !== it.eBI || outBQ !== it.eBQ) begin
        nFails++;
        $display("FAIL %s: got A=%h/%h B=%h/%h expected A=%h/%h B=%h/%h", it.tag,
                 outAI, outAQ, outBI, outBQ, it.eAI, it.eAQ, it.eBI, it.eBQ);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    testCfg = 10'b11_0000_0011; normAI = 8'h11; normBI = 8'h22;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (outAI !== 8'h00 || outAQ !== 8'h00 || outBI !== 8'h00 || outBQ !== 8'h00) begin
      nFails++;
      $display("FAIL R1: got %h %h %h %h expected 00 00 00 00", outAI, outAQ, outBI, outBQ);
    end
    testCfg = '0;
    @(posedge clk); #1 rst_n = 1'b1;

    // R2, R8: pass-through with varied data
    step(10'h000, 8'h12, 8'h34, 8'h56, 8'h78, "R2");
    step(10'h000, 8'hff, 8'h00, 8'h80, 8'h01, "R2 R8");
    // R9: bit 1 and pattern bits ignored when inactive
    step(10'h3fe, 8'ha1, 8'hb2, 8'hc3, 8'hd4, "R9");
    step(10'h2aa, 8'h5a, 8'ha5, 8'h0f, 8'hf0, "R9");
    // R3, R4: static patterns
    step({8'ha5, 2'b01}, 8'h00, 8'h00, 8'h00, 8'h00, "R3 R4");
    step({8'h00, 2'b01}, 8'h33, 8'h33, 8'h33, 8'h33, "R3 R4 R8");
    step({8'hff, 2'b01}, 8'h33, 8'h33, 8'h33, 8'h33, "R3 R4 R8");
    step({8'h3c, 2'b01}, 8'h44, 8'h44, 8'h44, 8'h44, "R3 R4");
    // R5, R6, R7: dynamic from static, long enough to wrap
    for (int i = 0; i < 300; i++)
      step({8'h99, 2'b11}, 8'h77, 8'h77, 8'h77, 8'h77, (i == 0) ? "R7" : "R5 R6");
    // back to static then dynamic: restart
    step({8'h81, 2'b01}, 8'h00, 8'h00, 8'h00, 8'h00, "R3 R4 R8");
    for (int i = 0; i < 5; i++)
      step({8'h00, 2'b11}, 8'h00, 8'h00, 8'h00, 8'h00, (i == 0) ? "R7" : "R5 R6");
    // inactive then dynamic: restart
    step(10'h000, 8'h9e, 8'h8d, 8'h7c, 8'h6b, "R2 R8");
    for (int i = 0; i < 4; i++)
      step({8'h55, 2'b11}, 8'h00, 8'h00, 8'h00, 8'h00, (i == 0) ? "R7" : "R5 R6");
    step(10'h002, 8'h01, 8'h02, 8'h03, 8'h04, "R9 R2");

    while (expQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule